// File: doc/BRIEF.md
# Serializing Transmit Lane with 8b/10b Line Coding

This block is one transmit lane of a backplane serializer. It produces its own character clock by dividing the serial bit clock by ten. On every falling edge of that character clock it latches one 10-bit parallel word, together with a mode bit. It then turns the word into ten serial bits and sends them out one per bit clock, the most significant bit first. The single-ended output stands for the differential line driver.

There are two modes. In encode mode the low byte and a control flag are coded with 8b/10b line coding. This stage keeps a running disparity and raises an error flag when a control character is requested that does not exist. In bypass mode the word is taken as already coded and goes to the line unchanged. The mode bit is latched with each character, so the two modes can be mixed character by character. A character leaves the lane a fixed five character periods after it was captured.

Top module: `serdes_tx_lane`

## Requirements
- R1: `char_clk` is high for five bit clocks and then low for five, repeating with a period of ten bit clocks. `tx_word` and `mode_enc` are captured at the bit-clock edge where `char_clk` falls.
- R2: When `mode_enc`=1 (encode), `tx_word[4:0]` is the 5-bit group EDCBA and `tx_word[7:5]` is the 3-bit group HGF. `tx_word[8]`=1 requests a control character. `tx_word[9]` has no effect on the output. The coded word puts the 6-bit sub-block abcdei on bits 9:4 (a on bit 9) and the 4-bit sub-block fghj on bits 3:0 (j on bit 0). Every coded word has four, five or six ones.
- R3: After reset the running disparity is negative. Each sub-block is chosen from the current disparity by the standard 8b/10b rules, including the alternate D.x.7 form, and the disparity changes only when an unbalanced sub-block is sent. Example: D0.0 sent first after reset gives 1001110100.
- R4: The only control characters that are coded as such are K28.0 to K28.7, K23.7, K27.7, K29.7 and K30.7. K28.5 sent first after reset gives 0011111010.
- R5: A control request for any other byte is coded as the data character of that byte. For that case `k_err` is 1 during the character period that begins one period after capture. Otherwise `k_err` is 0.
- R6: When `mode_enc`=0 (bypass), the 10-bit word is sent unchanged, the running disparity is left as it was, and `k_err` stays 0.
- R7: The ten bits of a character are sent on consecutive bit clocks, word bit 9 first and bit 0 last. The encoded order is therefore a, b, c, d, e, i, f, g, h, j.
- R8: The first bit of a character appears on `sout` at the falling edge of `char_clk` that comes five character periods after its capture. The other nine bits follow on the next nine bit clocks.
- R9: While `rst_n` is low, `sout`=0, `k_err`=0 and `char_clk`=1. After reset the pipeline is empty, so the five character periods that begin with the first falling edge of `char_clk` carry all-zero bits.
- R10: Each character is coded according to the mode bit latched with it, so the mode can alternate from one character to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bit clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_enc | input | 1 | 1 selects encode, 0 selects bypass; latched with each character |
| tx_word | input | 10 | Parallel character: byte, control flag, spare bit (encode) or a ready-coded word (bypass) |
| char_clk | output | 1 | Character clock, bit clock divided by ten |
| sout | output | 1 | Serial line bit |
| k_err | output | 1 | Invalid control request, one character period long |

## Verification
The assertions check four things on every clock. A falling edge of the character clock always lines up with the capture strobe. Every coded word is within the disparity bounds and goes in the direction the prior running disparity demands. A bypassed character never raises `k_err`. The serial line is quiet on the edge where reset is released. Only the bench scenarios can show the exact code values over a full byte sweep, the twelve legal control codes, the bit order on the wire, the five-character latency, and that the disparity really restarts negative after a reset in the middle of a run. They compare every serialized character against an independent coding model.

// File: rtl/txl_pkg.sv
// Package txl_pkg
// Shared constants and 8b/10b sub-block tables for the transmit lane.
// The tables give the code sent while the running disparity is negative.
// Code literals are written in transmit order, leftmost bit first (a..i, f..j).
package txl_pkg;

    localparam int CODE_W = 10;
    localparam int BYTE_W = 8;
    localparam int SUB6_W = 6;
    localparam int SUB4_W = 4;

    // Data 5b/6b group, negative-disparity column
    function automatic logic [SUB6_W-1:0] grp6_neg(input logic [4:0] x);
        logic [SUB6_W-1:0] c;
        case (x)
            5'd0:  c = 6'b100111;
            5'd1:  c = 6'b011101;
            5'd2:  c = 6'b101101;
            5'd3:  c = 6'b110001;
            5'd4:  c = 6'b110101;
            5'd5:  c = 6'b101001;
            5'd6:  c = 6'b011001;
            5'd7:  c = 6'b111000;
            5'd8:  c = 6'b111001;
            5'd9:  c = 6'b100101;
            5'd10: c = 6'b010101;
            5'd11: c = 6'b110100;
            5'd12: c = 6'b001101;
            5'd13: c = 6'b101100;
            5'd14: c = 6'b011100;
            5'd15: c = 6'b010111;
            5'd16: c = 6'b011011;
            5'd17: c = 6'b100011;
            5'd18: c = 6'b010011;
            5'd19: c = 6'b110010;
            5'd20: c = 6'b001011;
            5'd21: c = 6'b101010;
            5'd22: c = 6'b011010;
            5'd23: c = 6'b111010;
            5'd24: c = 6'b110011;
            5'd25: c = 6'b100110;
            5'd26: c = 6'b010110;
            5'd27: c = 6'b110110;
            5'd28: c = 6'b001110;
            5'd29: c = 6'b101110;
            5'd30: c = 6'b011110;
            default: c = 6'b101011;
        endcase
        return c;
    endfunction

    // Data 3b/4b group, negative-disparity column (primary x.7)
    function automatic logic [SUB4_W-1:0] grp4_neg(input logic [2:0] y);
        logic [SUB4_W-1:0] c;
        case (y)
            3'd0: c = 4'b1011;
            3'd1: c = 4'b1001;
            3'd2: c = 4'b0101;
            3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;
            3'd5: c = 4'b1010;
            3'd6: c = 4'b0110;
            default: c = 4'b1110;
        endcase
        return c;
    endfunction

    // Control 3b/4b group that follows the K28 6-bit group, negative column
    function automatic logic [SUB4_W-1:0] k28grp4_neg(input logic [2:0] y);
        logic [SUB4_W-1:0] c;
        case (y)
            3'd0: c = 4'b1011;
            3'd1: c = 4'b0110;
            3'd2: c = 4'b1010;
            3'd3: c = 4'b1100;
            3'd4: c = 4'b1101;
            3'd5: c = 4'b0101;
            3'd6: c = 4'b1001;
            default: c = 4'b0111;
        endcase
        return c;
    endfunction

    // True when the byte names one of the twelve legal control characters
    function automatic logic ctrl_legal(input logic [BYTE_W-1:0] b);
        logic [4:0] x;
        logic [2:0] y;
        x = b[4:0];
        y = b[7:5];
        return (x == 5'd28) ||
               ((y == 3'd7) && ((x == 5'd23) || (x == 5'd27) ||
                                (x == 5'd29) || (x == 5'd30)));
    endfunction

endpackage

// File: rtl/txl_chardiv.sv
// Module txl_chardiv
// Divides the bit clock by DIV to make the character clock and a one-cycle
// capture strobe on the edge where the character clock falls.
// Assumes DIV is even and at least 4.
module txl_chardiv #(
    parameter int DIV = 10
) (
    input  logic clk,
    input  logic rst_n,
    output logic char_clk,
    output logic strobe
);

    localparam int HALF = DIV / 2;
    localparam int CW   = $clog2(DIV);
    localparam logic [CW-1:0] LAST_C = CW'(DIV - 1);
    localparam logic [CW-1:0] HALF_C = CW'(HALF);
    localparam logic [CW-1:0] FALL_C = CW'(HALF - 1);

    logic [CW-1:0] phase;
    logic [CW-1:0] phase_nxt;

    // Next phase of the bit counter, wrapping at DIV
    always_comb begin
        phase_nxt = (phase == LAST_C) ? '0 : phase + 1'b1;
    end

    // Capture strobe: the edge that leaves the high half of the period
    assign strobe = (phase == FALL_C);

    // Phase counter and registered character clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase    <= '0;
            char_clk <= 1'b1;
        end else begin
            phase    <= phase_nxt;
            char_clk <= (phase_nxt < HALF_C);
        end
    end

    // R1: the character clock only falls on the capture edge
    p_fall_on_strobe_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(char_clk) |-> $past(strobe))
        else $error("char_clk fell away from capture strobe");

endmodule

// File: rtl/txl_encoder.sv
// Module txl_encoder
// Capture register plus 8b/10b coding stage. On each strobe it latches the
// parallel word and mode, and registers the code of the previous capture.
// Running disparity: 0 = negative, 1 = positive; negative after reset.
// In bypass mode the latched word passes through and disparity holds.
module txl_encoder
    import txl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic              in_enc,
    input  logic [CODE_W-1:0] in_word,
    output logic [CODE_W-1:0] out_word,
    output logic              k_err
);

    logic [CODE_W-1:0] cap_w;
    logic              cap_enc;
    logic              rd_q;

    logic [4:0]        grp5;
    logic [2:0]        grp3;
    logic              kreq;
    logic              kok;
    logic              k28;
    logic [SUB6_W-1:0] c6_base;
    logic [SUB6_W-1:0] c6;
    logic              rd_mid;
    logic              use_alt7;
    logic [SUB4_W-1:0] c4_base;
    logic [SUB4_W-1:0] c4;
    logic              rd_end;

    // Latch the parallel character and its mode on the capture strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_w   <= '0;
            cap_enc <= 1'b0;
        end else if (strobe) begin
            cap_w   <= in_word;
            cap_enc <= in_enc;
        end
    end

    // Decode the request fields of the captured character
    always_comb begin
        grp5 = cap_w[4:0];
        grp3 = cap_w[7:5];
        kreq = cap_w[BYTE_W];
        kok  = kreq && ctrl_legal(cap_w[BYTE_W-1:0]);
        k28  = kok && (grp5 == 5'd28);
    end

    // 6-bit sub-block: pick the column from the current disparity
    always_comb begin
        c6_base = k28 ? 6'b001111 : grp6_neg(grp5);
        if (rd_q && (($countones(c6_base) != 3) || (c6_base == 6'b111000)))
            c6 = ~c6_base;
        else
            c6 = c6_base;
        rd_mid = rd_q ^ ($countones(c6) != 3);
    end

    // 4-bit sub-block: alternate x.7 form and control forms
    always_comb begin
        use_alt7 = (grp3 == 3'd7) &&
                   (kok ||
                    (!rd_mid && ((grp5 == 5'd17) || (grp5 == 5'd18) || (grp5 == 5'd20))) ||
                    ( rd_mid && ((grp5 == 5'd11) || (grp5 == 5'd13) || (grp5 == 5'd14))));
        if (k28)
            c4_base = k28grp4_neg(grp3);
        else if (use_alt7)
            c4_base = 4'b0111;
        else
            c4_base = grp4_neg(grp3);
        if (rd_mid && (($countones(c4_base) != 2) || (c4_base == 4'b1100) || k28))
            c4 = ~c4_base;
        else
            c4 = c4_base;
        rd_end = rd_mid ^ ($countones(c4) != 2);
    end

    // Register the coded word, disparity and error for the next stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_word <= '0;
            rd_q     <= 1'b0;
            k_err    <= 1'b0;
        end else if (strobe) begin
            out_word <= cap_enc ? {c6, c4} : cap_w;
            rd_q     <= cap_enc ? rd_end : rd_q;
            k_err    <= cap_enc && kreq && !kok;
        end
    end

    // R2: a coded word is never more than one bit off balance
    p_code_balance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cap_enc) |=> (($countones(out_word) >= 4) && ($countones(out_word) <= 6)))
        else $error("coded word out of balance");

    // R3: a coded word leans against the disparity that preceded it
    p_disp_dir_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && cap_enc) |=> ($past(rd_q) ? ($countones(out_word) <= 5)
                                             : ($countones(out_word) >= 5)))
        else $error("coded word pushes disparity the wrong way");

    // R6: a bypassed character never flags a control error
    p_bypass_noerr_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && !cap_enc) |=> !k_err)
        else $error("k_err raised in bypass");

endmodule

// File: rtl/txl_delay.sv
// Module txl_delay
// Character-rate delay line of DEPTH stages, advanced on the strobe.
// Cleared to zero in reset; DEPTH = 0 is a plain wire.
module txl_delay #(
    parameter int W     = 10,
    parameter int DEPTH = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         strobe,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (DEPTH == 0) begin : g_wire
            assign q = d;
        end else begin : g_pipe
            logic [W-1:0] stg [DEPTH];
            for (genvar i = 0; i < DEPTH; i++) begin : g_stage
                // One character of delay per stage
                always_ff @(posedge clk) begin
                    if (!rst_n)
                        stg[i] <= '0;
                    else if (strobe)
                        stg[i] <= (i == 0) ? d : stg[(i == 0) ? 0 : i - 1];
                end
            end
            assign q = stg[DEPTH-1];
        end
    endgenerate

endmodule

// File: rtl/txl_serializer.sv
// Module txl_serializer
// Parallel-load shift register. On load the top bit goes straight to the
// registered line output and the rest shift out, MSB first, one per clock.
// Assumes load pulses no more often than every W clocks.
module txl_serializer #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] par,
    output logic         sout
);

    logic [W-2:0] rest;

    // Load a new word or shift the remainder onto the line
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sout <= 1'b0;
            rest <= '0;
        end else if (load) begin
            sout <= par[W-1];
            rest <= par[W-2:0];
        end else begin
            sout <= rest[W-2];
            rest <= {rest[W-3:0], 1'b0};
        end
    end

    // R9: the line is quiet on the edge where reset is released
    p_idle_reset_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !sout)
        else $error("sout not idle out of reset");

endmodule

// File: rtl/serdes_tx_lane.sv
// Module serdes_tx_lane
// One serial transmit lane: character clock divider, capture and 8b/10b
// coding stage, character delay line and 10:1 serializer. Capture to first
// serial bit is LAT_CHARS character periods. Assumes LAT_CHARS >= 2.
module serdes_tx_lane
    import txl_pkg::*;
#(
    parameter int LAT_CHARS = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_enc,
    input  logic [CODE_W-1:0] tx_word,
    output logic              char_clk,
    output logic              sout,
    output logic              k_err
);

    localparam int CHAR_DIV = CODE_W;
    localparam int DLY      = LAT_CHARS - 2;

    logic              strobe;
    logic [CODE_W-1:0] coded;
    logic [CODE_W-1:0] to_ser;

    txl_chardiv #(.DIV(CHAR_DIV)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .char_clk (char_clk),
        .strobe   (strobe)
    );

    txl_encoder u_enc (
        .clk      (clk),
        .rst_n    (rst_n),
        .strobe   (strobe),
        .in_enc   (mode_enc),
        .in_word  (tx_word),
        .out_word (coded),
        .k_err    (k_err)
    );

    txl_delay #(.W(CODE_W), .DEPTH(DLY)) u_dly (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (strobe),
        .d      (coded),
        .q      (to_ser)
    );

    txl_serializer #(.W(CODE_W)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (strobe),
        .par   (to_ser),
        .sout  (sout)
    );

endmodule

// File: tb/test_serdes_tx_lane.sv
// Scoreboard bench: the driver codes each character with its own model and
// queues the expectation; a monitor pops and compares as bits leave the lane.
module test_serdes_tx_lane;

    localparam int LAT = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_enc = 1'b0;
    logic [9:0] tx_word = '0;
    logic       char_clk;
    logic       sout;
    logic       k_err;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    typedef struct {
        int         idx;
        logic [9:0] code;
        logic       err;
        string      tag;
    } item_t;

    item_t q_out[$];
    item_t q_err[$];

    int         fall_idx = 0;
    logic       prev_cc = 1'b1;
    bit         collecting = 1'b0;
    int         bitpos = 0;
    logic [9:0] got = '0;
    item_t      cur;
    logic       m_rd = 1'b0;

    always #10 clk = ~clk;

    serdes_tx_lane i_serdes_tx_lane (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_enc (mode_enc),
        .tx_word  (tx_word),
        .char_clk (char_clk),
        .sout     (sout),
        .k_err    (k_err)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [9:0] act, input logic [9:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %b expected %b", req, what, act, exp);
        end
    endtask

    function automatic logic [5:0] m6(input logic [4:0] x);
        case (x)
            0: return 6'b100111;  1: return 6'b011101;  2: return 6'b101101;
            3: return 6'b110001;  4: return 6'b110101;  5: return 6'b101001;
            6: return 6'b011001;  7: return 6'b111000;  8: return 6'b111001;
            9: return 6'b100101; 10: return 6'b010101; 11: return 6'b110100;
           12: return 6'b001101; 13: return 6'b101100; 14: return 6'b011100;
           15: return 6'b010111; 16: return 6'b011011; 17: return 6'b100011;
           18: return 6'b010011; 19: return 6'b110010; 20: return 6'b001011;
           21: return 6'b101010; 22: return 6'b011010; 23: return 6'b111010;
           24: return 6'b110011; 25: return 6'b100110; 26: return 6'b010110;
           27: return 6'b110110; 28: return 6'b001110; 29: return 6'b101110;
           30: return 6'b011110; default: return 6'b101011;
        endcase
    endfunction

    function automatic logic [3:0] m4(input logic [2:0] y, input bit ctl28);
        if (ctl28) begin
            case (y)
                0: return 4'b1011; 1: return 4'b0110; 2: return 4'b1010; 3: return 4'b1100;
                4: return 4'b1101; 5: return 4'b0101; 6: return 4'b1001; default: return 4'b0111;
            endcase
        end
        case (y)
            0: return 4'b1011; 1: return 4'b1001; 2: return 4'b0101; 3: return 4'b1100;
            4: return 4'b1101; 5: return 4'b1010; 6: return 4'b0110; default: return 4'b1110;
        endcase
    endfunction

    // Reference coder for R2..R6; updates the bench's running disparity
    task automatic model(input logic enc, input logic [9:0] w,
                         output logic [9:0] code, output logic err);
        logic [4:0] x;
        logic [2:0] y;
        logic [5:0] s6;
        logic [3:0] s4;
        bit legal, ctl, alt;
        x = w[4:0];
        y = w[7:5];
        if (!enc) begin
            code = w;
            err  = 1'b0;
            return;
        end
        legal = (x == 28) || (y == 7 && (x == 23 || x == 27 || x == 29 || x == 30));
        ctl   = w[8] && legal;
        err   = w[8] && !legal;
        s6 = (ctl && x == 28) ? 6'b001111 : m6(x);
        if (m_rd && ($countones(s6) != 3 || s6 == 6'b111000)) s6 = ~s6;
        if ($countones(s6) != 3) m_rd = ~m_rd;
        alt = (y == 7) && (ctl || (!m_rd && (x == 17 || x == 18 || x == 20)) ||
                                  (m_rd && (x == 11 || x == 13 || x == 14)));
        s4 = alt && !(ctl && x == 28) ? 4'b0111 : m4(y, ctl && x == 28);
        if (m_rd && ($countones(s4) != 2 || s4 == 4'b1100 || (ctl && x == 28))) s4 = ~s4;
        if ($countones(s4) != 2) m_rd = ~m_rd;
        code = {s6, s4};
    endtask

    // Driver: present one character for the next capture and queue its result
    task automatic send(input logic enc, input logic [9:0] w, input string tag);
        item_t it;
        logic [9:0] c;
        logic e;
        @(posedge char_clk);
        @(negedge clk);
        mode_enc = enc;
        tx_word  = w;
        model(enc, w, c, e);
        it.idx = fall_idx + 1;
        it.code = c;
        it.err = e;
        it.tag = tag;
        q_out.push_back(it);
        q_err.push_back(it);
    endtask

    // Monitor: track character periods, compare k_err and serial characters
    always @(negedge clk) begin
        if (!rst_n) begin
            fall_idx = 0;
            prev_cc = 1'b1;
            collecting = 1'b0;
            q_out.delete();
            q_err.delete();
        end else begin
            if (prev_cc && !char_clk) begin
                fall_idx++;
                if (q_err.size() > 0 && q_err[0].idx == fall_idx - 1) begin
                    cur = q_err.pop_front();
                    chk(k_err == cur.err, (cur.err ? "R5" : cur.tag), "k_err",
                        {9'd0, k_err}, {9'd0, cur.err});
                end
                if (fall_idx <= LAT)
                    chk(sout == 1'b0, "R9", "empty pipeline bit", {9'd0, sout}, 10'd0);
                if (q_out.size() > 0 && q_out[0].idx == fall_idx - LAT) begin
                    cur = q_out.pop_front();
                    collecting = 1'b1;
                    bitpos = 0;
                    got = '0;
                end
            end
            prev_cc = char_clk;
            if (collecting) begin
                got[9 - bitpos] = sout;
                bitpos++;
                if (bitpos == 10) begin
                    chk(got == cur.code, cur.tag, "serial character (R7 R8 order/latency)",
                        got, cur.code);
                    collecting = 1'b0;
                end
            end
        end
    end

    // R1: measure char_clk high and low widths after reset
    int run_len = 0;
    int r1_checks = 0;
    logic cc_last = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            run_len = 0;
            cc_last = 1'b1;
        end else begin
            if (char_clk != cc_last) begin
                if (r1_checks > 0 && r1_checks < 9)
                    chk(run_len == 5, "R1", "char_clk half period",
                        10'(run_len), 10'd5);
                r1_checks++;
                run_len = 0;
            end
            run_len++;
            cc_last = char_clk;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        mode_enc = 1'b0;
        tx_word = '0;
        m_rd = 1'b0;
        repeat (3) @(negedge clk);
        chk(sout == 1'b0, "R9", "sout in reset", {9'd0, sout}, 10'd0);
        chk(k_err == 1'b0, "R9", "k_err in reset", {9'd0, k_err}, 10'd0);
        chk(char_clk == 1'b1, "R9", "char_clk in reset", {9'd0, char_clk}, 10'd1);
        repeat (10) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic drain_and_check();
        repeat ((LAT + 3) * 10) @(negedge clk);
        chk(q_out.size() == 0, "R8", "characters never delivered",
            10'(q_out.size()), 10'd0);
    endtask

    initial begin
        do_reset();
        // R4: comma first after reset, R3 starting disparity
        send(1'b1, {2'b01, 8'hBC}, "R4");
        send(1'b1, {2'b00, 8'hB5}, "R3");
        // R2: spare bit 9 set has no effect in encode mode
        send(1'b1, {2'b10, 8'h00}, "R2");
        send(1'b1, {2'b10, 8'h7E}, "R2");
        // R3: full data byte sweep, disparity carried throughout
        for (int b = 0; b < 256; b++)
            send(1'b1, {2'b00, 8'(b)}, "R3");
        // R4: every legal control character
        begin
            logic [7:0] kl [12] = '{8'h1C, 8'h3C, 8'h5C, 8'h7C, 8'h9C, 8'hBC,
                                   8'hDC, 8'hFC, 8'hF7, 8'hFB, 8'hFD, 8'hFE};
            for (int i = 0; i < 12; i++)
                send(1'b1, {2'b01, kl[i]}, "R4");
        end
        // R5: illegal control requests go out as data
        send(1'b1, {2'b01, 8'h00}, "R5");
        send(1'b1, {2'b01, 8'h55}, "R5");
        send(1'b1, {2'b01, 8'hE7}, "R5");
        send(1'b1, {2'b00, 8'hE7}, "R5");
        // R6/R7: bypass words, including single-bit order probes
        send(1'b0, 10'h200, "R7");
        send(1'b0, 10'h001, "R7");
        send(1'b0, 10'h3FF, "R6");
        send(1'b0, {2'b01, 8'h00}, "R6");
        send(1'b0, 10'h2AA, "R6");
        // R10: alternate modes per character
        for (int i = 0; i < 8; i++)
            send(i[0], {2'b00, 8'(8'h11 * i)}, "R10");
        drain_and_check();
        // R3/R9: reset mid-run restarts disparity negative
        do_reset();
        send(1'b1, {2'b00, 8'h00}, "R3");
        send(1'b1, {2'b01, 8'hBC}, "R4");
        send(1'b1, {2'b00, 8'h0F}, "R3");
        drain_and_check();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL R8 watchdog expired: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule